// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block runs single read or write transactions on a two-wire PHY management bus. A host loads a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value, and then pulses `start_i`. The block produces the management clock, drives the data line with its output-enable and samples the returning data line. At the end it raises `done_o` for one cycle. On a read, the 16 sampled bits appear on `rdata_o`.

Every frame takes exactly 64 bit slots. Each slot has a low half, in which the bit is placed on the line, and a high half. Any sampling happens on the rising edge between the two halves. The length of each half, in system clocks, is set by the parameter `HALF_CYC`. Its default of 20 gives 2.5 MHz from a 100 MHz system clock. When there is no frame, the bus sits with the clock low and the line released.

Top module: `mdio_frame_master`

## Requirements
- R1: A frame has exactly 64 clock pulses. Its first 32 slots carry the value 1 with output-enable high.
- R2: Slots 32–33 carry 0 then 1. Slots 34–35 carry the opcode: 1,0 when `rd_i`=1 (read) and 0,1 when `rd_i`=0 (write). All four slots are driven.
- R3: Slots 36–40 carry the PHY address and slots 41–45 the register address, each most significant bit first and driven.
- R4: On a read, slot 46 is released (output-enable low). Slots 47–62 are released, and `mdi_i` is captured at each of their rising clock edges into `rdata_o`, first bit as bit 15. `rdata_o` then holds that value until the next read completes; a write leaves it unchanged.
- R5: On a read, slot 63 is released. After the frame ends, the clock is low and output-enable is low.
- R6: On a write, slots 46–47 are driven as 1 then 0. Slots 48–63 carry the write value, most significant bit first, all driven.
- R7: The management clock stays high for exactly `HALF_CYC` system clocks and low for `HALF_CYC` system clocks within a frame. The data line and output-enable never change while the clock is high.
- R8: `busy_o` rises in the cycle after an accepted start and stays high until `done_o`. `done_o` is a single-cycle pulse that coincides with `busy_o` falling. A start while busy is ignored: it does not alter the frame in flight and it does not start another one.
- R9: After reset, the clock is low, output-enable is low, and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a frame |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Value to write |
| mdi_i | input | 1 | Data line as seen from the bus |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Data value to drive |
| mdoe_o | output | 1 | Output-enable for the data line |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| rdata_o | output | 16 | Value captured by the last read |

## Verification
Writes are run with address pairs 0/5 and 31/31 and with the values 0xA55A and 0x8001. These catch field swaps, bit-order reversal and dropped end bits. Reads return 0x796D, 0xFFFF and 0x0001 from a modelled PHY. These tell apart an off-by-one sampling slot, a wrong capture order and a turnaround of the wrong length. A write placed after a read shows that the read result is held. A second start injected mid-frame, using the opposite direction and different addresses, must change neither the frame nor the count of clock pulses.

// File: rtl/mdio_fm_pkg.sv
package mdio_fm_pkg;

   localparam int ADDR_W      = 5;
   localparam int DATA_W      = 16;
   localparam int SLOTS       = 64;
   localparam int SLOT_W      = $clog2(SLOTS);
   localparam int PRE_SLOTS   = 32;
   localparam int RD_TA_SLOT  = 46;
   localparam int RD_FIRST    = RD_TA_SLOT + 1;
   localparam int RD_LAST     = RD_FIRST + DATA_W - 1;
   localparam int LAST_SLOT   = SLOTS - 1;

   typedef enum logic {ST_IDLE, ST_SHIFT} fm_state_e;

   // full bit image of one frame, slot 0 at the MSB
   function automatic logic [SLOTS-1:0] fm_pack(input logic rd,
                                                input logic [ADDR_W-1:0] pa,
                                                input logic [ADDR_W-1:0] ra,
                                                input logic [DATA_W-1:0] wd);
      logic [1:0] op;
      logic [DATA_W+1:0] tail;
      op   = rd ? 2'b10 : 2'b01;
      tail = rd ? '0 : {2'b10, wd};
      return {{PRE_SLOTS{1'b1}}, 2'b01, op, pa, ra, tail};
   endfunction

   // whether the master drives the line during a slot
   function automatic logic fm_drive(input logic rd, input logic [SLOT_W-1:0] slot);
      return !rd || (slot < SLOT_W'(RD_TA_SLOT));
   endfunction

endpackage

// File: rtl/mdio_fm_div.sv
module mdio_fm_div #(
   parameter int HALF_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

   if (HALF_CYC < 1) begin : g_bad_half
      $error("HALF_CYC must be at least 1");
   end

   if (HALF_CYC == 1) begin : g_every
      assign tick_o = run_i;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      assign tick_o = run_i && (cnt_q == CNT_W'(HALF_CYC - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       cnt_q <= '0;
         else if (!run_i)  cnt_q <= '0;
         else if (tick_o)  cnt_q <= '0;
         else              cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_fm_rx.sv
module mdio_fm_rx #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_i,
   input  logic              bit_i,
   output logic [DATA_W-1:0] data_o
);
   if (DATA_W < 2) begin : g_bad_w
      $error("DATA_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_o <= '0;
      else if (shift_i) data_o <= {data_o[DATA_W-2:0], bit_i};
   end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
   import mdio_fm_pkg::*;
#(
   parameter int HALF_CYC = 20
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        rd_i,
   input  logic [4:0]  phy_addr_i,
   input  logic [4:0]  reg_addr_i,
   input  logic [15:0] wdata_i,
   input  logic        mdi_i,
   output logic        mdc_o,
   output logic        mdo_o,
   output logic        mdoe_o,
   output logic        busy_o,
   output logic        done_o,
   output logic [15:0] rdata_o
);
   fm_state_e         state_q;
   logic [SLOTS-1:0]  frame_q;
   logic [SLOT_W-1:0] slot_q;
   logic              rd_q;
   logic              tick;
   logic              sample;
   logic              last_slot;

   mdio_fm_div #(.HALF_CYC(HALF_CYC)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (busy_o),
      .tick_o (tick)
   );

   assign sample = (state_q == ST_SHIFT) && tick && !mdc_o && rd_q
                && (slot_q >= SLOT_W'(RD_FIRST)) && (slot_q <= SLOT_W'(RD_LAST));

   mdio_fm_rx #(.DATA_W(DATA_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (sample),
      .bit_i   (mdi_i),
      .data_o  (rdata_o)
   );

   assign last_slot = (slot_q == SLOT_W'(LAST_SLOT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         frame_q <= '0;
         slot_q  <= '0;
         rd_q    <= 1'b0;
         mdc_o   <= 1'b0;
         mdo_o   <= 1'b0;
         mdoe_o  <= 1'b0;
         busy_o  <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  logic [SLOTS-1:0] img;
                  img      = fm_pack(rd_i, phy_addr_i, reg_addr_i, wdata_i);
                  frame_q <= img << 1;
                  mdo_o   <= img[SLOTS-1];
                  mdoe_o  <= 1'b1;
                  mdc_o   <= 1'b0;
                  rd_q    <= rd_i;
                  slot_q  <= '0;
                  busy_o  <= 1'b1;
                  state_q <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!mdc_o) begin
                     mdc_o <= 1'b1;
                  end else if (last_slot) begin
                     mdc_o   <= 1'b0;
                     mdo_o   <= 1'b0;
                     mdoe_o  <= 1'b0;
                     busy_o  <= 1'b0;
                     done_o  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     mdc_o   <= 1'b0;
                     slot_q  <= slot_q + 1'b1;
                     mdo_o   <= frame_q[SLOTS-1];
                     frame_q <= frame_q << 1;
                     mdoe_o  <= fm_drive(rd_q, slot_q + 1'b1);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
   parameter int HALF_CYC = 20
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic mdc_o,
   input logic mdo_o,
   input logic mdoe_o,
   input logic busy_o,
   input logic done_o
);
   int unsigned hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_cnt <= 0;
      else if (mdc_o) hi_cnt <= hi_cnt + 1;
      else            hi_cnt <= 0;
   end

   AST_LINE_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      mdc_o |-> ($stable(mdo_o) && $stable(mdoe_o)));                    // R7
   AST_HIGH_HALF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdc_o) |-> (hi_cnt == HALF_CYC));                             // R7
   AST_CLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mdc_o |-> busy_o);                                                  // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mdc_o && !mdoe_o));                                   // R5
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));                             // R8
   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));                                  // R8
   AST_BUSY_DROP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);                                          // R8
endmodule

bind mdio_frame_master mdio_frame_master_chk #(.HALF_CYC(HALF_CYC)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .mdc_o   (mdc_o),
   .mdo_o   (mdo_o),
   .mdoe_o  (mdoe_o),
   .busy_o  (busy_o),
   .done_o  (done_o)
);

// File: tb/mdio_frame_master_tb_top.sv
`timescale 1ns/1ps
module mdio_frame_master_tb_top;
   localparam int HALF = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        rd_i = 1'b0;
   logic [4:0]  phy_addr_i = '0;
   logic [4:0]  reg_addr_i = '0;
   logic [15:0] wdata_i = '0;
   logic        mdi_i;
   logic        mdc_o, mdo_o, mdoe_o, busy_o, done_o;
   logic [15:0] rdata_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int rises = 0;
   int hi_total = 0;
   logic [15:0] phy_val = '0;
   logic cap_mdo [64];
   logic cap_oe  [64];

   always #5 clk = ~clk;

   mdio_frame_master #(.HALF_CYC(HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
      .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
      .mdi_i(mdi_i), .mdc_o(mdc_o), .mdo_o(mdo_o), .mdoe_o(mdoe_o),
      .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o)
   );

   // PHY model: returns phy_val in slots 47..62, line pulled high otherwise
   assign mdi_i = (rises >= 47 && rises <= 62) ? phy_val[62 - rises] : 1'b1;

   always @(posedge mdc_o) begin
      if (rises < 64) begin
         cap_mdo[rises] = mdo_o;
         cap_oe[rises]  = mdoe_o;
      end
      rises = rises + 1;
   end

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (mdc_o) hi_total = hi_total + 1;
      if (cyc > 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_bad = n_bad + 1;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic test_reset();
      @(negedge clk);
      chk(mdc_o == 1'b0 && mdoe_o == 1'b0, "R9", "clk/oe after reset", {mdc_o, mdoe_o}, 0);
      chk(busy_o == 1'b0 && done_o == 1'b0, "R9", "busy/done after reset", {busy_o, done_o}, 0);
   endtask

   // runs one frame, optionally injecting a conflicting start mid-frame
   task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] wd, input logic [15:0] pv, input bit inject);
      logic exp_b [64];
      logic exp_e [64];
      logic [15:0] rdata_before;
      int busy_gaps = 0;
      int t = 0;
      int dones = 0;
      bit seen = 0;
      string rq;
      for (int i = 0; i < 32; i++) begin exp_b[i] = 1'b1; exp_e[i] = 1'b1; end
      exp_b[32] = 1'b0; exp_b[33] = 1'b1;
      exp_b[34] = rd;   exp_b[35] = !rd;
      for (int i = 0; i < 5; i++) begin
         exp_b[36 + i] = pa[4 - i];
         exp_b[41 + i] = ra[4 - i];
      end
      for (int i = 32; i < 64; i++) exp_e[i] = !rd || (i < 46);
      if (!rd) begin
         exp_b[46] = 1'b1; exp_b[47] = 1'b0;
         for (int i = 0; i < 16; i++) exp_b[48 + i] = wd[15 - i];
      end else begin
         for (int i = 46; i < 64; i++) exp_b[i] = 1'b0;
      end

      @(negedge clk);
      rises = 0; hi_total = 0; phy_val = pv;
      rdata_before = rdata_o;
      rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R8", "busy after start", busy_o, 1);
      while (!seen && t < 10000) begin
         @(negedge clk);
         t = t + 1;
         if (inject && t == 700) begin
            rd_i = !rd; phy_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd; start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         if (done_o) begin seen = 1; dones = dones + 1; end
         else if (!busy_o) busy_gaps = busy_gaps + 1;
      end
      chk(seen, "R8", "done seen", seen, 1);
      chk(busy_gaps == 0, "R8", "busy low inside frame", busy_gaps, 0);
      chk(busy_o == 1'b0, "R8", "busy with done", busy_o, 0);
      @(negedge clk);
      chk(done_o == 1'b0, "R8", "done width", done_o, 0);
      chk(mdc_o == 1'b0 && mdoe_o == 1'b0, "R5", "bus idle after frame", {mdc_o, mdoe_o}, 0);
      chk(rises == 64, "R1", "clock pulse count", rises, 64);
      chk(hi_total == 64 * HALF, "R7", "total clock-high cycles", hi_total, 64 * HALF);
      for (int i = 0; i < 64; i++) begin
         if (i < 32) rq = "R1";
         else if (i < 36) rq = "R2";
         else if (i < 46) rq = "R3";
         else if (!rd) rq = "R6";
         else if (i < 63) rq = "R4";
         else rq = "R5";
         chk(cap_oe[i] == exp_e[i], rq, $sformatf("oe slot %0d", i), cap_oe[i], exp_e[i]);
         if (exp_e[i])
            chk(cap_mdo[i] == exp_b[i], rq, $sformatf("data slot %0d", i), cap_mdo[i], exp_b[i]);
      end
      if (rd) chk(rdata_o == pv, "R4", "read value", rdata_o, pv);
      else    chk(rdata_o == rdata_before, "R4", "read value held over write", rdata_o, rdata_before);
      if (inject) begin
         repeat (300) @(negedge clk);
         chk(rises == 64 && busy_o == 1'b0, "R8", "no frame from ignored start", rises, 64);
      end
   endtask

   task automatic test_write_basic();  run_frame(1'b0, 5'd0,  5'd5,  16'hA55A, 16'h0, 1'b0); endtask
   task automatic test_write_edges();  run_frame(1'b0, 5'd31, 5'd31, 16'h8001, 16'h0, 1'b0); endtask
   task automatic test_read_mixed();   run_frame(1'b1, 5'd0,  5'd1,  16'h0,    16'h796D, 1'b0); endtask
   task automatic test_read_ones();    run_frame(1'b1, 5'd21, 5'd10, 16'h0,    16'hFFFF, 1'b0); endtask
   task automatic test_read_lsb();     run_frame(1'b1, 5'd9,  5'd18, 16'h0,    16'h0001, 1'b0); endtask
   task automatic test_hold_on_write(); run_frame(1'b0, 5'd3, 5'd2,  16'h1234, 16'hBEEF, 1'b0); endtask
   task automatic test_busy_ignore();  run_frame(1'b0, 5'd10, 5'd17, 16'h5AA5, 16'h0, 1'b1); endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      test_reset();
      test_write_basic();
      test_write_edges();
      test_read_mixed();
      test_read_ones();
      test_read_lsb();
      test_hold_on_write();
      test_busy_ignore();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule